// File: doc/BRIEF.md
# Instrument Configuration Register Bank

This block is the small register file that a plug-in instrument module exposes on a 16-bit register bus. A word-offset decoder selects among six kinds of location. The first is a write-only control word that opens the module's memory window, keeps the module from pulling the shared fail line, and holds the module in a commanded reset. The second is a read/write window offset. The rest are fixed identification words and a version word whose hardware revision fields come from parameters.

From the stored offset the block computes where the module's memory window starts. In 24-bit address mode the base is the offset shifted left by 8. In 32-bit mode it is shifted left by 16. A comparator then flags every incoming memory address that falls inside the window while the window is enabled. Two resets behave differently. The hard reset input clears everything. The commanded reset only drives an output and leaves the stored offset alone.

Top module: `cfg_regbank`

## Requirements
- R1: While `rst_n` is low, and after it rises, `mem_en`, `fail_inhibit` and `soft_rst` are 0 and the offset word at byte offset 0x06 reads 0x0000. The hard reset acts without waiting for a clock edge.
- R2: A write to byte offset 0x04 takes effect at that clock edge. Bit 15 sets `mem_en` and bit 1 sets `fail_inhibit`. Bits 14 to 2 change no output.
- R3: Bit 0 of the control word is a level hold. `soft_rst` is high from the second clock edge after a write with bit 0 set, and it falls on the second edge after a write with bit 0 clear.
- R4: A write to offset 0x06 stores bits 15 to 5. A read of 0x06 returns them with bits 4 to 0 always 0.
- R5: The offset word keeps its value while `soft_rst` is high. It still accepts writes while `soft_rst` is high, and it changes only on a write to 0x06.
- R6: `win_base` equals offset×256 when `mode_a32` is 0 and offset×65536 when `mode_a32` is 1.
- R7: `win_hit` is 1 exactly when `mem_en` is 1 and base ≤ A < base + 2^WIN_LOG2. A is `mem_addr` in 32-bit mode and `mem_addr[23:0]` in 24-bit mode, and the sum is taken without wrap.
- R8: Offsets 0x0A and 0x0C read 0xFFFF. Offset 0x0E reads {0xFF, HW_MAJOR[3:0], HW_MINOR[3:0]}.
- R9: Reads of offset 0x04 and of every undecoded even offset return 0xFFFF. Writes to undecoded offsets change no output and leave the offset word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| bus_wr | input | 1 | Write strobe, one cycle per word |
| bus_addr | input | ADDR_W | Byte offset in configuration space (bit 0 ignored) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| mode_a32 | input | 1 | 1 selects 32-bit window addressing, 0 selects 24-bit |
| mem_addr | input | BASE_W | Incoming memory address to test |
| win_base | output | BASE_W | Computed window start address |
| win_hit | output | 1 | Address falls inside the enabled window |
| mem_en | output | 1 | Memory window enabled |
| fail_inhibit | output | 1 | Module must not drive the fail line |
| soft_rst | output | 1 | Commanded reset to the rest of the module |

## Verification
The hardest corner to reach is the window near the top of the 24-bit space. There, base plus window size passes 2^24, and the upper address byte must be ignored. The bench gets there by writing offset 0xFFE0 and probing both window edges with garbage in the top address byte, in both address modes. The other hard case is the commanded reset. The bench raises it and writes a new offset while it is held. It then releases it and checks that the offset word holds across both steps. Each point is checked at the exact clock after the control write.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;

   // word slot = byte offset >> 1
   typedef enum logic [2:0] {
      SLOT_CTRL = 3'd2,
      SLOT_OFFS = 3'd3,
      SLOT_SERH = 3'd5,
      SLOT_SERL = 3'd6,
      SLOT_VERS = 3'd7
   } slot_e;

   localparam int unsigned CTRL_EN_BIT   = 15;
   localparam int unsigned CTRL_INH_BIT  = 1;
   localparam int unsigned CTRL_HOLD_BIT = 0;

   typedef struct packed {
      logic win_en;
      logic fail_inh;
      logic hold;
   } ctrl_t;

endpackage

// File: rtl/cfg_ctrl_reg.sv
module cfg_ctrl_reg
   import cfg_regbank_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output ctrl_t             ctrl_q,
   output logic              soft_rst
);

   generate
      if (DATA_W <= CTRL_EN_BIT) begin : g_bad_width
         $error("cfg_ctrl_reg: DATA_W too small for enable bit");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         soft_rst <= 1'b0;
      end else begin
         if (wr_en) begin
            ctrl_q.win_en   <= wdata[CTRL_EN_BIT];
            ctrl_q.fail_inh <= wdata[CTRL_INH_BIT];
            ctrl_q.hold     <= wdata[CTRL_HOLD_BIT];
         end
         soft_rst <= ctrl_q.hold;
      end
   end

endmodule

// File: rtl/cfg_offset_reg.sv
module cfg_offset_reg #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned DROP_LSB = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] off_val
);

   generate
      if (DROP_LSB >= DATA_W) begin : g_bad_drop
         $error("cfg_offset_reg: DROP_LSB must be below DATA_W");
      end

      if (DROP_LSB == 0) begin : g_full
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q <= '0;
            else if (wr_en) q <= wdata;
         end
         assign off_val = q;
      end else begin : g_trim
         localparam int unsigned KEEP_W = DATA_W - DROP_LSB;
         logic [KEEP_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q <= '0;
            else if (wr_en) q <= wdata[DATA_W-1:DROP_LSB];
         end
         assign off_val = {q, {DROP_LSB{1'b0}}};
      end
   endgenerate

endmodule

// File: rtl/cfg_win_decode.sv
module cfg_win_decode #(
   parameter int unsigned OFF_W     = 16,
   parameter int unsigned BASE_W    = 32,
   parameter int unsigned NARROW_W  = 24,
   parameter int unsigned NARROW_SH = 8,
   parameter int unsigned WIDE_SH   = 16,
   parameter int unsigned WIN_LOG2  = 13
) (
   input  logic              win_en,
   input  logic              mode_wide,
   input  logic [OFF_W-1:0]  off_val,
   input  logic [BASE_W-1:0] addr,
   output logic [BASE_W-1:0] base,
   output logic              hit
);

   localparam int unsigned   CMP_W    = BASE_W + 1;
   localparam logic [CMP_W-1:0] WIN_SIZE = CMP_W'(1) << WIN_LOG2;

   generate
      if (WIN_LOG2 >= BASE_W) begin : g_bad_win
         $error("cfg_win_decode: window larger than address space");
      end
      if (NARROW_W > BASE_W || OFF_W + WIDE_SH > BASE_W) begin : g_bad_space
         $error("cfg_win_decode: address widths inconsistent");
      end
   endgenerate

   logic [BASE_W-1:0] base_narrow, base_wide, addr_eff, diff;
   logic [BASE_W-1:0] narrow_mask;

   assign narrow_mask = (BASE_W'(1) << NARROW_W) - BASE_W'(1);
   assign base_narrow = BASE_W'(off_val) << NARROW_SH;
   assign base_wide   = BASE_W'(off_val) << WIDE_SH;

   always_comb begin
      base     = mode_wide ? base_wide : base_narrow;
      addr_eff = mode_wide ? addr : (addr & narrow_mask);
      diff     = addr_eff - base;
      hit      = win_en && (addr_eff >= base) && ({1'b0, diff} < WIN_SIZE);
   end

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
   import cfg_regbank_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned BASE_W   = 32,
   parameter int unsigned WIN_LOG2 = 13,
   parameter int unsigned OFF_DROP = 5,
   parameter int unsigned HW_MAJOR = 1,
   parameter int unsigned HW_MINOR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   input  logic              mode_a32,
   input  logic [BASE_W-1:0] mem_addr,
   output logic [BASE_W-1:0] win_base,
   output logic              win_hit,
   output logic              mem_en,
   output logic              fail_inhibit,
   output logic              soft_rst
);

   localparam int unsigned DATA_W   = 16;
   localparam logic [DATA_W-1:0] FILL = '1;
   localparam logic [DATA_W-1:0] VERS_WORD =
      {8'hFF, 4'(HW_MAJOR), 4'(HW_MINOR)};

   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("cfg_regbank: ADDR_W must be at least 5");
      end
      if (HW_MAJOR > 15 || HW_MINOR > 15) begin : g_bad_rev
         $error("cfg_regbank: revision fields are 4 bits");
      end
   endgenerate

   // address decode
   logic        in_page;
   slot_e       slot;
   logic        wr_ctrl, wr_offs;

   assign in_page = (bus_addr[ADDR_W-1:4] == '0);
   assign slot    = slot_e'(bus_addr[3:1]);
   assign wr_ctrl = bus_wr && in_page && (slot == SLOT_CTRL);
   assign wr_offs = bus_wr && in_page && (slot == SLOT_OFFS);

   ctrl_t             ctrl_q;
   logic [DATA_W-1:0] off_val;

   cfg_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_ctrl),
      .wdata    (bus_wdata),
      .ctrl_q   (ctrl_q),
      .soft_rst (soft_rst)
   );

   cfg_offset_reg #(.DATA_W(DATA_W), .DROP_LSB(OFF_DROP)) u_offs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_offs),
      .wdata   (bus_wdata),
      .off_val (off_val)
   );

   cfg_win_decode #(
      .OFF_W    (DATA_W),
      .BASE_W   (BASE_W),
      .WIN_LOG2 (WIN_LOG2)
   ) u_win (
      .win_en    (ctrl_q.win_en),
      .mode_wide (mode_a32),
      .off_val   (off_val),
      .addr      (mem_addr),
      .base      (win_base),
      .hit       (win_hit)
   );

   assign mem_en       = ctrl_q.win_en;
   assign fail_inhibit = ctrl_q.fail_inh;

   // read mux
   always_comb begin
      bus_rdata = FILL;
      if (in_page) begin
         unique case (slot)
            SLOT_OFFS: bus_rdata = off_val;
            SLOT_VERS: bus_rdata = VERS_WORD;
            default:   bus_rdata = FILL;
         endcase
      end
   end

endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk #(
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [15:0]       bus_wdata,
   input logic [15:0]       bus_rdata,
   input logic              mem_en,
   input logic              fail_inhibit,
   input logic              soft_rst,
   input logic              win_hit,
   input logic [15:0]       off_q
);

   logic ctrl_wr, offs_wr;
   assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(8'h04));
   assign offs_wr = bus_wr && (bus_addr == ADDR_W'(8'h06));

   assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (mem_en == $past(bus_wdata[15])) &&
                  (fail_inhibit == $past(bus_wdata[1])));

   assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_wr |=> $stable(mem_en) && $stable(fail_inhibit));

   assert_rst_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(soft_rst) |-> $past(ctrl_wr && bus_wdata[0], 2));

   assert_offs_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !offs_wr |=> $stable(off_q));

   assert_offs_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(8'h06)) |-> (bus_rdata[4:0] == 5'd0));

   assert_hit_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      win_hit |-> mem_en);

   assert_serial_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(8'h0A)) |-> (bus_rdata == 16'hFFFF));

endmodule

bind cfg_regbank cfg_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_wr       (bus_wr),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .bus_rdata    (bus_rdata),
   .mem_en       (mem_en),
   .fail_inhibit (fail_inhibit),
   .soft_rst     (soft_rst),
   .win_hit      (win_hit),
   .off_q        (off_val)
);

// File: tb/cfg_regbank_test.sv
module cfg_regbank_test;

   localparam int CLK_P    = 10;
   localparam int ADDR_W   = 8;
   localparam int WIN_LOG2 = 13;
   localparam int MAJ      = 3;
   localparam int MIN      = 9;
   localparam longint WSIZE = 64'd1 << WIN_LOG2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [15:0]       bus_wdata = '0;
   logic [15:0]       bus_rdata;
   logic              mode_a32 = 1'b0;
   logic [31:0]       mem_addr = '0;
   logic [31:0]       win_base;
   logic              win_hit, mem_en, fail_inhibit, soft_rst;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #(CLK_P/2) clk = ~clk;

   cfg_regbank #(
      .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .HW_MAJOR(MAJ), .HW_MINOR(MIN)
   ) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_a32(mode_a32),
      .mem_addr(mem_addr), .win_base(win_base), .win_hit(win_hit),
      .mem_en(mem_en), .fail_inhibit(fail_inhibit), .soft_rst(soft_rst)
   );

   task automatic check(input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
      @(negedge clk);
   endtask

   task automatic probe(input logic [31:0] a, input logic en);
      longint base, aeff;
      logic   exp;
      mem_addr = a;
      #1;
      base = mode_a32 ? longint'(win_base) : longint'(win_base);
      aeff = mode_a32 ? longint'(a) : longint'(a & 32'h00FF_FFFF);
      exp  = en && (aeff >= base) && ((aeff - base) < WSIZE);
      check("R7 hit", 64'(win_hit), 64'(exp));
      @(negedge clk);
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] r;
      logic [15:0] v;
      longint eb;

      // R1 hard reset
      repeat (3) @(negedge clk);
      check("R1 mem_en in reset", 64'(mem_en), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 mem_en", 64'(mem_en), 0);
      check("R1 fail_inhibit", 64'(fail_inhibit), 0);
      check("R1 soft_rst", 64'(soft_rst), 0);
      rd(8'h06, r);
      check("R1 offset", 64'(r), 0);

      // R8 identification words
      rd(8'h0A, r); check("R8 serial high", 64'(r), 64'hFFFF);
      rd(8'h0C, r); check("R8 serial low", 64'(r), 64'hFFFF);
      rd(8'h0E, r); check("R8 version", 64'(r), 64'(16'hFF00 | (MAJ << 4) | MIN));

      // R9 read sweep of all even offsets except 0x06 and 0x0E
      for (int a = 0; a < 256; a += 2) begin
         if (a != 6 && a != 14) begin
            rd(8'(a), r);
            check("R9 read", 64'(r), 64'hFFFF);
         end
      end

      // R9 writes to undecoded offsets
      for (int a = 0; a < 256; a += 2) begin
         if (a != 4 && a != 6) wr(8'(a), 16'hFFFF);
      end
      check("R9 mem_en", 64'(mem_en), 0);
      check("R9 fail_inhibit", 64'(fail_inhibit), 0);
      @(negedge clk);
      check("R9 soft_rst", 64'(soft_rst), 0);
      rd(8'h06, r); check("R9 offset untouched", 64'(r), 0);

      // R2 control patterns
      begin
         logic [15:0] pats [5] = '{16'h8000, 16'h0002, 16'h7FFC, 16'h8002, 16'h0000};
         foreach (pats[i]) begin
            wr(8'h04, pats[i]);
            check("R2 mem_en", 64'(mem_en), 64'(pats[i][15]));
            check("R2 fail_inhibit", 64'(fail_inhibit), 64'(pats[i][1]));
            @(negedge clk);
            check("R2 no soft_rst", 64'(soft_rst), 0);
            rd(8'h04, r); check("R9 ctrl read", 64'(r), 64'hFFFF);
         end
      end

      // R4 offset write/read sweep
      for (int i = 0; i < 256; i++) begin
         v = 16'(i * 257) ^ 16'(i << 3);
         wr(8'h06, v);
         rd(8'h06, r);
         check("R4 offset readback", 64'(r), 64'(v & 16'hFFE0));
      end

      // R3 / R5 commanded reset
      wr(8'h06, 16'h1234);
      wr(8'h04, 16'h8001);
      check("R3 one edge after write", 64'(soft_rst), 0);
      @(negedge clk);
      check("R3 asserted", 64'(soft_rst), 1);
      check("R2 enable during hold", 64'(mem_en), 1);
      rd(8'h06, r); check("R5 offset kept", 64'(r), 64'h1220);
      wr(8'h06, 16'hABCD);
      rd(8'h06, r); check("R5 write during hold", 64'(r), 64'hABC0);
      wr(8'h04, 16'h8000);
      check("R3 still held", 64'(soft_rst), 1);
      @(negedge clk);
      check("R3 released", 64'(soft_rst), 0);
      rd(8'h06, r); check("R5 offset after release", 64'(r), 64'hABC0);

      // R6 / R7 window sweep
      for (int m = 0; m < 2; m++) begin
         mode_a32 = m[0];
         for (int k = 0; k < 18; k++) begin
            if (k < 16)       v = 16'(k * 16'h1111) & 16'hFFE0;
            else if (k == 16) v = 16'hFFE0;
            else              v = 16'h0000;
            wr(8'h06, v);
            #1;
            eb = m ? (longint'(v) << 16) : (longint'(v) << 8);
            check("R6 base", 64'(win_base), 64'(eb));
            @(negedge clk);
            if (eb > 0) probe(32'(eb - 1), 1'b1);
            probe(32'(eb), 1'b1);
            probe(32'(eb + WSIZE - 1), 1'b1);
            probe(32'(eb + WSIZE), 1'b1);
            if (m == 0) probe(32'hA500_0000 | 32'(eb + 5), 1'b1);
            if (m == 1) probe(32'hA500_0000 ^ 32'(eb + 5), 1'b1);
         end
      end

      // R7 window disabled
      wr(8'h04, 16'h0000);
      mode_a32 = 1'b0;
      wr(8'h06, 16'h4000);
      probe(32'h0040_0010, 1'b0);
      check("R7 disabled hit", 64'(win_hit), 0);

      // R1 hard reset mid-run
      wr(8'h04, 16'h8003);
      wr(8'h06, 16'hFFFF);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 async mem_en", 64'(mem_en), 0);
      check("R1 async fail_inhibit", 64'(fail_inhibit), 0);
      check("R1 async soft_rst", 64'(soft_rst), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(8'h06, r); check("R1 offset cleared", 64'(r), 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule